// File: doc/BRIEF.md
# SPI Command Frame Validator

This block sits behind the serial port of a system controller and judges every command frame the host sends. While chip select is low it samples the data line on each rising serial clock, counts the rising edges and shifts the outgoing status word out on the falling edges. When chip select returns high it checks two things: the edge count must equal the frame length, and a parity bit inside the frame must match the XOR of a fixed payload range. Only a frame that passes both checks is handed to the control logic. It arrives as a one-cycle update strobe carrying the mode-select and configuration-select fields.

A frame with a wrong checksum is dropped silently and the previous fields stay in force. A frame with the wrong edge count is treated as corrupted. It raises a sticky fail flag and a one-cycle interrupt pulse unless the interrupt is masked. It also makes the next transfer shift out the previous output word again instead of fresh status. The serial pins are brought into the system clock domain through synchronizers, so the serial clock must be several times slower than the system clock.

Frame layout, most significant bit sent first: bit 15 reserved, bit 14 checksum, bits 13..6 payload, bits 5..3 configuration select, bits 2..0 mode select.

Top module: `spi_frame_validator`

## Requirements
- R1: After synchronous reset, upd_valid, spi_fail and irq are 0, upd_mode and upd_cfg are 0, and miso is 0.
- R2: A frame of exactly 16 rising clock edges with a correct checksum produces upd_valid high for exactly one system clock. In that same cycle upd_mode shows frame bits 2..0 and upd_cfg shows bits 5..3. The frame is sampled MSB first. The strobe is visible after the third system clock edge that follows the chip-select rise being driven.
- R3: The checksum bit 14 must equal the XOR of bits 13 down to 6. On a mismatch there is no strobe and upd_mode and upd_cfg keep their previous values.
- R4: A transfer whose rising-edge count differs from 16 produces no strobe, keeps upd_mode and upd_cfg, and sets spi_fail in the same cycle a strobe would have appeared.
- R5: A length error pulses irq high for exactly one cycle, in the cycle spi_fail is set, unless irq_mask is high, in which case irq stays low.
- R6: The output word is {1, status_in[14:0]}, with bit 15 always 1. It is captured when chip select falls and presented MSB first on miso, advancing one bit per falling serial clock.
- R7: The transfer right after a length-error transfer shifts out the same word as the corrupted transfer did. After any other transfer the next word is fresh status.
- R8: spi_fail stays set until a frame is accepted. A checksum-failed frame with a correct length leaves spi_fail unchanged.
- R9: The edge counter saturates, so a transfer of 48 edges, which would wrap a 5-bit counter back to 16, is still a length error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| status_in | input | 15 | Fresh status bits 14..0 for the next output word |
| irq_mask | input | 1 | Suppresses the length-error interrupt |
| spi_miso | output | 1 | Serial data to host |
| upd_valid | output | 1 | One-cycle strobe for an accepted frame |
| upd_mode | output | 3 | Mode-select field of the last accepted frame |
| upd_cfg | output | 3 | Configuration-select field of the last accepted frame |
| spi_fail | output | 1 | Sticky corrupted-frame flag |
| irq | output | 1 | One-cycle length-error interrupt |

## Verification
Each pin passes through two synchronizer flops and an edge register. As a result the strobe, spi_fail and irq change after the third system clock edge that follows the driven chip-select rise, and miso moves three edges after a serial clock fall. Inputs are driven on falling system clock edges. The driver samples the frame results exactly three falling edges after raising chip select, and also checks that they were still quiet one edge earlier and that irq has dropped one edge later. Miso is sampled four system clocks after the data change, just before each serial rising edge. Expected fields are queued by the driver and popped by a monitor whenever the strobe is seen, so an extra or missing strobe is caught.

// File: rtl/spi_fv_pkg.sv
package spi_fv_pkg;
    localparam int FRAME_W  = 16;
    localparam int FLD_W    = 3;
    localparam int MODE_LSB = 0;
    localparam int CFG_LSB  = 3;
    localparam int SUM_LO   = 6;
    localparam int SUM_HI   = 13;
    localparam int SUM_POS  = 14;
    localparam int CNT_W    = $clog2(FRAME_W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [FLD_W-1:0] cfg;
        logic [FLD_W-1:0] mode;
    } cmd_fields_t;

    // received word holds frame bits 14..0
    function automatic logic sum_ok(input logic [FRAME_W-2:0] w);
        return w[SUM_POS] == (^w[SUM_HI:SUM_LO]);
    endfunction

    function automatic cmd_fields_t fields_of(input logic [FRAME_W-2:0] w);
        cmd_fields_t f;
        f.mode = w[MODE_LSB +: FLD_W];
        f.cfg  = w[CFG_LSB  +: FLD_W];
        return f;
    endfunction
endpackage

// File: rtl/spi_fv_sync.sv
module spi_fv_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[i]}};
            else     chain <= {chain[STAGES-2:0], d_in[i]};
        end
        assign d_out[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_fv_shift.sv
module spi_fv_shift
    import spi_fv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_fall,
    input  logic               cs_active,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] load_word,
    output logic [FRAME_W-2:0] rx_word,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               miso
);
    logic [FRAME_W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_word <= '0;
            bit_cnt <= '0;
        end else if (cs_fall) begin
            tx_q    <= load_word;
            bit_cnt <= '0;
        end else if (cs_active) begin
            if (sclk_rise) begin
                rx_word <= {rx_word[FRAME_W-3:0], mosi_s};
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_fv_check.sv
module spi_fv_check
    import spi_fv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_rise,
    input  logic [FRAME_W-2:0] rx_word,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic               irq_mask,
    output logic               upd_valid,
    output cmd_fields_t        fields,
    output logic               spi_fail,
    output logic               irq,
    output logic               repeat_next
);
    logic len_ok, chk_ok;
    assign len_ok = (bit_cnt == CNT_W'(FRAME_W));
    assign chk_ok = sum_ok(rx_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid   <= 1'b0;
            fields      <= '0;
            spi_fail    <= 1'b0;
            irq         <= 1'b0;
            repeat_next <= 1'b0;
        end else begin
            upd_valid <= 1'b0;
            irq       <= 1'b0;
            if (cs_rise) begin
                repeat_next <= !len_ok;
                if (!len_ok) begin
                    spi_fail <= 1'b1;
                    irq      <= !irq_mask;
                end else if (chk_ok) begin
                    upd_valid <= 1'b1;
                    fields    <= fields_of(rx_word);
                    spi_fail  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_frame_validator.sv
module spi_frame_validator
    import spi_fv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sclk,
    input  logic               spi_csn,
    input  logic               spi_mosi,
    input  logic [FRAME_W-2:0] status_in,
    input  logic               irq_mask,
    output logic               spi_miso,
    output logic               upd_valid,
    output logic [FLD_W-1:0]   upd_mode,
    output logic [FLD_W-1:0]   upd_cfg,
    output logic               spi_fail,
    output logic               irq
);
    logic [2:0] pins_s;
    logic       sclk_q, csn_q;
    logic       sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic [FRAME_W-2:0] rx_word;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] load_word, last_word;
    logic               repeat_next;
    cmd_fields_t        fields;

    spi_fv_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst),
        .d_in({spi_mosi, spi_csn, spi_sclk}),
        .d_out(pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            csn_q     <= 1'b1;
            last_word <= '0;
        end else begin
            sclk_q <= pins_s[0];
            csn_q  <= pins_s[1];
            if (cs_fall) last_word <= load_word;
        end
    end

    assign sclk_rise = pins_s[0] & ~sclk_q;
    assign sclk_fall = ~pins_s[0] & sclk_q;
    assign cs_fall   = ~pins_s[1] & csn_q;
    assign cs_rise   = pins_s[1] & ~csn_q;
    assign load_word = repeat_next ? last_word : {1'b1, status_in};

    spi_fv_shift u_shift (
        .clk(clk), .rst(rst),
        .cs_fall(cs_fall), .cs_active(~pins_s[1]),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(pins_s[2]), .load_word(load_word),
        .rx_word(rx_word), .bit_cnt(bit_cnt), .miso(spi_miso)
    );

    spi_fv_check u_check (
        .clk(clk), .rst(rst),
        .cs_rise(cs_rise), .rx_word(rx_word), .bit_cnt(bit_cnt),
        .irq_mask(irq_mask),
        .upd_valid(upd_valid), .fields(fields), .spi_fail(spi_fail),
        .irq(irq), .repeat_next(repeat_next)
    );

    assign upd_mode = fields.mode;
    assign upd_cfg  = fields.cfg;
endmodule

// File: rtl/spi_fv_checker.sv
module spi_fv_checker (
    input logic       clk,
    input logic       rst,
    input logic       upd_valid,
    input logic [2:0] upd_mode,
    input logic [2:0] upd_cfg,
    input logic       spi_fail,
    input logic       irq,
    input logic       irq_mask
);
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !upd_valid);
    p_fields_held_r3: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |-> ($stable(upd_mode) && $stable(upd_cfg)));
    p_irq_with_fail_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> spi_fail);
    p_irq_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> !$past(irq_mask));
    p_fail_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_fail) |-> upd_valid);
    p_accept_no_fail_r8: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> !spi_fail);
endmodule

bind spi_frame_validator spi_fv_checker u_chk (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_mode(upd_mode),
    .upd_cfg(upd_cfg), .spi_fail(spi_fail), .irq(irq), .irq_mask(irq_mask)
);

// File: tb/sim_spi_frame_validator.sv
`timescale 1ns/1ps
module sim_spi_frame_validator;
    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, mask = 1'b0;
    logic [14:0] status = '0;
    logic miso, upd_valid, spi_fail, irq;
    logic [2:0] upd_mode, upd_cfg;

    int total = 0, bad = 0;
    bit done = 0;
    logic [5:0] exp_q[$];
    logic [15:0] prev_tx = '0;
    bit rep = 0, fail_m = 0;
    logic [2:0] held_mode = '0, held_cfg = '0;

    always #2.5 clk = ~clk;

    spi_frame_validator u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .status_in(status), .irq_mask(mask), .spi_miso(miso),
        .upd_valid(upd_valid), .upd_mode(upd_mode), .upd_cfg(upd_cfg),
        .spi_fail(spi_fail), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] m, input logic [2:0] c,
                                       input logic [7:0] p, input bit good);
        return {1'b1, (^p) ^ !good, p, c, m};
    endfunction

    // monitor: pops an expected item per observed strobe
    always @(negedge clk) begin
        if (!rst && upd_valid) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected strobe", 1, 0);
            else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                chk({upd_cfg, upd_mode} == e, "R2 fields", {upd_cfg, upd_mode}, e);
            end
        end
    end

    task automatic xfer(input logic [15:0] w, input int nclk, input logic [14:0] st,
                        input bit msk);
        logic [15:0] got, exp_tx;
        bit len_ok, s_ok;
        got = '0;
        len_ok = (nclk == 16);
        s_ok = (w[14] == ^w[13:6]);
        exp_tx = rep ? prev_tx : {1'b1, st};
        @(negedge clk); status = st; mask = msk; csn = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i < 16) got[15-i] = miso;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        for (int i = 0; i < 16 && i < nclk; i++)
            chk(got[15-i] == exp_tx[15-i], rep ? "R7 repeated bit" : "R6 out bit",
                got[15-i], exp_tx[15-i]);
        if (len_ok && s_ok) exp_q.push_back({w[5:3], w[2:0]});
        repeat (8) @(negedge clk);
        csn = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(upd_valid == 0 && irq == 0, "R2 result not early", {upd_valid, irq}, 0);
        @(negedge clk);
        chk(upd_valid == (len_ok && s_ok), "R2 R3 R4 strobe", upd_valid, len_ok && s_ok);
        if (!len_ok) fail_m = 1;
        else if (s_ok) fail_m = 0;
        chk(spi_fail == fail_m, "R4 R8 spi_fail", spi_fail, fail_m);
        chk(irq == (!len_ok && !msk), "R5 irq", irq, !len_ok && !msk);
        if (len_ok && s_ok) begin held_mode = w[2:0]; held_cfg = w[5:3]; end
        else chk(upd_mode == held_mode && upd_cfg == held_cfg, "R3 R4 R9 fields kept",
                 {upd_cfg, upd_mode}, {held_cfg, held_mode});
        @(negedge clk);
        chk(irq == 0, "R5 irq single", irq, 0);
        prev_tx = exp_tx;
        rep = !len_ok;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(upd_valid == 0 && spi_fail == 0 && irq == 0, "R1 flags", {upd_valid, spi_fail, irq}, 0);
        chk(upd_mode == 0 && upd_cfg == 0 && miso == 0, "R1 fields", {upd_cfg, upd_mode, miso}, 0);

        xfer(mk(3'd3, 3'd5, 8'hA6, 1), 16, 15'h25A5, 0);   // R2 R6
        xfer(mk(3'd6, 3'd2, 8'h3C, 0), 16, 15'h7001, 0);   // R3
        xfer(mk(3'd7, 3'd1, 8'h01, 1), 16, 15'h0000, 0);   // R2
        xfer(mk(3'd2, 3'd4, 8'h55, 1), 15, 15'h1234, 0);   // R4 R5
        xfer(mk(3'd1, 3'd6, 8'hF0, 1), 16, 15'h0F0F, 0);   // R7 R8
        xfer(mk(3'd5, 3'd5, 8'h81, 1), 48, 15'h3333, 1);   // R9 R5 masked
        xfer(mk(3'd4, 3'd3, 8'h77, 0), 16, 15'h4444, 0);   // R8 R7
        xfer(mk(3'd0, 3'd7, 8'hFF, 1), 16, 15'h5A5A, 0);   // R6 fresh
        xfer(mk(3'd2, 3'd2, 8'h10, 1), 17, 15'h6666, 0);   // R4 R5
        xfer(mk(3'd6, 3'd0, 8'h2B, 1), 16, 15'h0101, 0);   // R7 R8

        chk(exp_q.size() == 0, "R2 missing strobe", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule